// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block is the digital regulation loop of an H-bridge controller. It sits between the user's two half-bridge commands and the gate-drive logic. When a digital over-current comparator fires while a high-side switch conducts, it overrides the user commands for a fixed off period, then hands control back. In phase/enable or PWM operation, the override makes the load recirculate through both high-side switches. In independent operation, it pulls any half-bridge that is commanded high down to low.

If the comparator is still asserted when an off period expires, a further full period follows at once, so a load whose current keeps rising cannot escape regulation. A change on the user commands ends any override in the same cycle. The comparator is masked while the outputs slew and for a blanking interval after the bridge leaves low-side recirculation. A sticky flag records that regulation happened. Off period lengths are derived from a clock-frequency parameter, and a 2-bit select picks one of four lengths.

Top module: `offtime_chopper`

## Requirements
- R1: With threshold select `thrSel` equal to 3'b000, the comparator never starts an off period, and the outputs equal `{cmdA,cmdB}`. Any nonzero code enables regulation.
- R2: A comparator assertion is ignored while neither command is high (no high-side switch on).
- R3: With `mode[1]`=0 (2'b00 phase/enable, 2'b01 PWM), a valid trip sampled at a clock edge drives `outA`=`outB`=1 from the next cycle for exactly one off period.
- R4: If `tripIn` is high in the last cycle of an off period, another full off period follows with no gap. This repeats until `tripIn` is low in a last cycle.
- R5: With `mode[1]`=1 (independent), a trip forces every output that is commanded high to 0 for the off period. An output commanded low stays 0.
- R6: Any change of `{cmdA,cmdB}` against the previous cycle ends the off period in that same cycle, and the outputs follow the commands combinationally.
- R7: The comparator is ignored in any cycle where `slewing` is high.
- R8: When the outputs go from 2'b00 to a nonzero value, the comparator is ignored in that cycle and in the following BLANK_CYC cycles.
- R9: A trip sets `tripFlag` from the next cycle. The flag stays set until a cycle with `clrFlag` high and no new trip.
- R10: The off period lasts (20 + 10*`offSel`) µs, that is (20+10*offSel)*CLK_KHZ/1000 cycles. `offSel` is sampled when a period starts or is extended.
- R11: A trip seen in the same cycle as a command change is discarded. After reset the outputs follow the commands and `tripFlag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tripIn | input | 1 | Over-threshold comparator result |
| mode | input | 2 | Bridge mode: 00 phase/enable, 01 PWM, 1x independent |
| cmdA | input | 1 | User command for half-bridge A (1 = high) |
| cmdB | input | 1 | User command for half-bridge B (1 = high) |
| slewing | input | 1 | Outputs are slewing |
| thrSel | input | 3 | Threshold code; 000 disables regulation |
| offSel | input | 2 | Off-time select: 20/30/40/50 µs |
| clrFlag | input | 1 | Clear-fault command for the status flag |
| outA | output | 1 | Half-bridge A output command |
| outB | output | 1 | Half-bridge B output command |
| tripFlag | output | 1 | Sticky regulation-occurred flag |

## Verification
Two functions can land in the same cycle. The first pair is the end of an off period and its extension, which competes with a user command change. The second pair is a fresh trip against a command change, or against the start of blanking when a forced 2'b00 pattern is released. Directed sequences line up a command toggle with the final off cycle, and with a trip. Random stimulus with rare command changes and a frequently asserted comparator produces further collisions. A cycle-level bench model judges each cycle's `outA`, `outB` and `tripFlag`, with the rule that command changes always win.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef struct packed {
    logic loadOff;   // start or extend an off period
    logic armBlank;  // start the blanking window
  } chopStrb_t;

  function automatic int offCycles(input int clkKhz, input logic [1:0] sel);
    return ((20 + 10 * int'(sel)) * clkKhz) / 1000;
  endfunction

endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int CLK_KHZ   = 1000,
  parameter int BLANK_CYC = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  chop_pkg::chopStrb_t strb,
  input  logic [1:0]          offSel,
  input  logic [1:0]          cmd,
  input  logic [1:0]          outNow,
  output logic                offZero,
  output logic                blankBusy,
  output logic                blankStart,
  output logic                cmdChg
);
  localparam int MAX_OFF = chop_pkg::offCycles(CLK_KHZ, 2'b11);
  localparam int OFF_W   = $clog2(MAX_OFF + 1);
  localparam int BLK_W   = $clog2(BLANK_CYC + 1) + 1;

  logic [OFF_W-1:0] offCnt;
  logic [BLK_W-1:0] blankCnt;
  logic [1:0]       prevCmd;
  logic [1:0]       prevOut;

  assign offZero    = (offCnt == '0);
  assign blankBusy  = (blankCnt != '0);
  assign blankStart = (prevOut == 2'b00) && (outNow != 2'b00);
  assign cmdChg     = (cmd != prevCmd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offCnt <= '0;
    end else if (strb.loadOff) begin
      offCnt <= OFF_W'(chop_pkg::offCycles(CLK_KHZ, offSel) - 1);
    end else if (!offZero) begin
      offCnt <= offCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blankCnt <= '0;
    end else if (strb.armBlank) begin
      blankCnt <= BLK_W'(BLANK_CYC);
    end else if (blankBusy) begin
      blankCnt <= blankCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCmd <= 2'b00;
      prevOut <= 2'b00;
    end else begin
      prevCmd <= cmd;
      prevOut <= outNow;
    end
  end
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tripIn,
  input  logic [1:0]          mode,
  input  logic [1:0]          cmd,
  input  logic                slewing,
  input  logic [2:0]          thrSel,
  input  logic                clrFlag,
  input  logic                offZero,
  input  logic                blankBusy,
  input  logic                blankStart,
  input  logic                cmdChg,
  output chop_pkg::chopStrb_t strb,
  output logic [1:0]          outNow,
  output logic                tripFlag,
  output logic                offActive
);
  logic [1:0] forced;
  logic       regEn;
  logic       hsOn;
  logic       tripValid;
  logic       extend;

  assign regEn  = (thrSel != 3'b000);
  assign hsOn   = |cmd;
  assign outNow = (offActive && !cmdChg) ? forced : cmd;

  assign tripValid = tripIn && regEn && hsOn && !slewing && !blankBusy &&
                     !blankStart && !cmdChg && !offActive;
  assign extend    = offActive && !cmdChg && offZero && tripIn;

  always_comb begin
    strb          = '0;
    strb.loadOff  = tripValid || extend;
    strb.armBlank = blankStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offActive <= 1'b0;
      forced    <= 2'b00;
    end else if (tripValid) begin
      offActive <= 1'b1;
      forced    <= mode[1] ? 2'b00 : 2'b11;
    end else if (offActive && (cmdChg || (offZero && !tripIn))) begin
      offActive <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tripFlag <= 1'b0;
    end else if (tripValid) begin
      tripFlag <= 1'b1;
    end else if (clrFlag) begin
      tripFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/offtime_chopper.sv
module offtime_chopper #(
  parameter int CLK_KHZ   = 1000,
  parameter int BLANK_CYC = 2 * CLK_KHZ / 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tripIn,
  input  logic [1:0] mode,
  input  logic       cmdA,
  input  logic       cmdB,
  input  logic       slewing,
  input  logic [2:0] thrSel,
  input  logic [1:0] offSel,
  input  logic       clrFlag,
  output logic       outA,
  output logic       outB,
  output logic       tripFlag
);
  chop_pkg::chopStrb_t strb;
  logic [1:0] cmd;
  logic [1:0] outNow;
  logic       offZero;
  logic       blankBusy;
  logic       blankStart;
  logic       cmdChg;
  logic       offActive;

  assign cmd  = {cmdA, cmdB};
  assign outA = outNow[1];
  assign outB = outNow[0];

  chop_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tripIn(tripIn), .mode(mode), .cmd(cmd),
    .slewing(slewing), .thrSel(thrSel), .clrFlag(clrFlag),
    .offZero(offZero), .blankBusy(blankBusy), .blankStart(blankStart),
    .cmdChg(cmdChg), .strb(strb), .outNow(outNow), .tripFlag(tripFlag),
    .offActive(offActive)
  );

  chop_timer #(.CLK_KHZ(CLK_KHZ), .BLANK_CYC(BLANK_CYC)) u_timer (
    .clk(clk), .rstN(rstN), .strb(strb), .offSel(offSel), .cmd(cmd),
    .outNow(outNow), .offZero(offZero), .blankBusy(blankBusy),
    .blankStart(blankStart), .cmdChg(cmdChg)
  );
endmodule

// File: rtl/offtime_chopper_chk.sv
module offtime_chopper_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tripIn,
  input logic       cmdA,
  input logic       cmdB,
  input logic       slewing,
  input logic [2:0] thrSel,
  input logic       clrFlag,
  input logic       outA,
  input logic       outB,
  input logic       tripFlag,
  input logic       offActive
);
  AST_PASS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !offActive |-> ({outA, outB} == {cmdA, cmdB}));  // R1
  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (thrSel == 3'b000 && !offActive) |=> !offActive);  // R1
  AST_NO_HS_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    ({cmdA, cmdB} == 2'b00 && !offActive) |=> !offActive);  // R2
  AST_CHANGE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ({cmdA, cmdB} != $past({cmdA, cmdB})) |-> ({outA, outB} == {cmdA, cmdB}));  // R6
  AST_SLEW_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (slewing && !offActive) |=> !offActive);  // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (tripFlag && !clrFlag) |=> tripFlag);  // R9
  AST_START_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(offActive) |-> tripFlag);  // R9
  AST_NO_TRIP_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (!tripIn && !offActive) |=> !offActive);  // R3
endmodule

bind offtime_chopper offtime_chopper_chk u_chk (
  .clk(clk), .rstN(rstN), .tripIn(tripIn), .cmdA(cmdA), .cmdB(cmdB),
  .slewing(slewing), .thrSel(thrSel), .clrFlag(clrFlag), .outA(outA),
  .outB(outB), .tripFlag(tripFlag), .offActive(offActive)
);

// File: tb/offtime_chopper_bench.sv
module offtime_chopper_bench;
  localparam int CLK_PERIOD = 10;
  localparam int KHZ        = 1000;
  localparam int BLANK      = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tripIn = 1'b0, cmdA = 1'b0, cmdB = 1'b0, slewing = 1'b0, clrFlag = 1'b0;
  logic [1:0] mode = 2'b00, offSel = 2'b00;
  logic [2:0] thrSel = 3'b001;
  logic outA, outB, tripFlag;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 1'b0;

  // bench model state
  bit mActive = 0, mFlag = 0;
  int mCnt = 0, mBlank = 0;
  logic [1:0] mForced = 2'b00, mPrevCmd = 2'b00, mPrevOut = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  offtime_chopper #(.CLK_KHZ(KHZ), .BLANK_CYC(BLANK)) u_offtime_chopper (
    .clk(clk), .rstN(rstN), .tripIn(tripIn), .mode(mode), .cmdA(cmdA),
    .cmdB(cmdB), .slewing(slewing), .thrSel(thrSel), .offSel(offSel),
    .clrFlag(clrFlag), .outA(outA), .outB(outB), .tripFlag(tripFlag)
  );

  function automatic int offLen(input logic [1:0] sel);
    return ((20 + 10 * int'(sel)) * KHZ) / 1000;
  endfunction

  function automatic logic [1:0] expOut();
    logic [1:0] c = {cmdA, cmdB};
    return (mActive && c == mPrevCmd) ? mForced : c;
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic modelUpdate();
    logic [1:0] c = {cmdA, cmdB};
    logic [1:0] o = expOut();
    bit chg = (c != mPrevCmd);
    bit bStart = (mPrevOut == 2'b00) && (o != 2'b00);
    bit valid = tripIn && (thrSel != 0) && (c != 0) && !slewing && (mBlank == 0)
                && !bStart && !chg && !mActive;
    if (valid) begin
      mActive = 1; mCnt = offLen(offSel) - 1; mForced = mode[1] ? 2'b00 : 2'b11;
    end else if (mActive) begin
      if (chg) mActive = 0;
      else if (mCnt == 0) begin
        if (tripIn) mCnt = offLen(offSel) - 1; else mActive = 0;
      end else mCnt--;
    end
    if (valid) mFlag = 1; else if (clrFlag) mFlag = 0;
    if (bStart) mBlank = BLANK; else if (mBlank > 0) mBlank--;
    mPrevCmd = c; mPrevOut = o;
  endtask

  // inputs already set after a negedge; check, then clock
  task automatic step(input string tag);
    #(CLK_PERIOD/4);
    check(tag, {outA, outB}, expOut());
    check(tag, {1'b0, tripFlag}, {1'b0, mFlag});
    @(posedge clk);
    modelUpdate();
    cycles++;
    @(negedge clk);
  endtask

  task automatic steps(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic finishUp();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finishUp();
  end

  initial begin
    int unused;
    unused = $urandom(32'd12345);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11: reset state
    step("R11 reset");
    // R1: disabled code
    thrSel = 3'b000; cmdA = 1; step("R1"); tripIn = 1; steps("R1", 10);
    tripIn = 0; thrSel = 3'b101; steps("R1", 2);
    // R2: no high side
    cmdA = 0; steps("R2", 2); tripIn = 1; steps("R2", 8); tripIn = 0;
    steps("R8", BLANK + 3);
    // R3 + R10: phase/enable trip, offSel 0
    cmdA = 1; steps("R8", BLANK + 3);
    mode = 2'b00; offSel = 2'b00; tripIn = 1; step("R3"); tripIn = 0;
    steps("R3,R10", offLen(2'b00) + 3);
    // R4: extension, hold trip through first period end
    mode = 2'b01; offSel = 2'b01; tripIn = 1; steps("R4", offLen(2'b01) + 5);
    tripIn = 0; steps("R4,R10", 2 * offLen(2'b01));
    // R9: clear flag
    clrFlag = 1; step("R9"); clrFlag = 0; steps("R9", 2);
    // R6: command change mid period
    tripIn = 1; step("R6"); tripIn = 0; steps("R6", 5);
    cmdB = 1; steps("R6", 3);
    // R11: trip in same cycle as change
    cmdA = 0; tripIn = 1; step("R11"); tripIn = 0; steps("R11", 3);
    // R5: independent
    mode = 2'b10; offSel = 2'b11; tripIn = 1; step("R5"); tripIn = 0;
    steps("R5,R10", offLen(2'b11) + 2);
    // R8: release of forced 00 starts blanking; trip held high
    cmdA = 1; cmdB = 0; steps("R8", BLANK + 2);
    offSel = 2'b00; tripIn = 1; step("R5"); tripIn = 0; steps("R5", offLen(2'b00) - 1);
    tripIn = 1; steps("R8", BLANK + 3); tripIn = 0; steps("R8", offLen(2'b00) + 2);
    // R7: slewing mask
    slewing = 1; tripIn = 1; steps("R7", 6); slewing = 0; tripIn = 0; steps("R7", 2);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) begin cmdA = $urandom_range(1); cmdB = $urandom_range(1); end
      if ($urandom_range(15) == 0) mode = 2'($urandom_range(3));
      if ($urandom_range(15) == 0) offSel = 2'($urandom_range(3));
      if ($urandom_range(31) == 0) thrSel = 3'($urandom_range(7));
      tripIn = ($urandom_range(2) != 0);
      slewing = ($urandom_range(9) == 0);
      clrFlag = ($urandom_range(19) == 0);
      step("R3,R4,R5,R6,R9");
    end
    finishUp();
  end
endmodule